// File: doc/BRIEF.md
# Round-Robin Crossbar Matching Scheduler

This block decides, for an N-by-N crossbar, which inputs connect to which outputs in the next transfer slot. Each input holds a separate queue for every output. It reports a request vector with one bit set for each output whose queue is not empty. A start pulse latches all request vectors. The scheduler then runs a fixed number of request/grant/accept rounds, one round per clock.

In each round, every still-free output offers itself to one still-free input that asked for it. The output picks by round robin, starting at its own grant pointer. Every input that receives offers takes one of them by round robin, starting at its own accept pointer. Pairs formed in a round are never undone. Later rounds only fill in inputs and outputs that are still free.

Only the pairs formed in the first round move the pointers. The output's pointer moves to the input just after the one it was paired with. The input's pointer moves to the output just after the one it took. Because of this, the pointers of different ports drift apart under heavy load. When the last round is done, the block raises a one-cycle done pulse. The matching stays on the outputs until the next start.

Top module: `islip_sched`

## Requirements
- R1: Reset clears all pointers to zero, holds done low and clears every match_valid bit. The first full request set after reset therefore pairs input k with output k.
- R2: Let T be the rising edge that accepts start. done goes high at edge T+ITER and returns low at the next edge.
- R3: match_valid[i] is set with match_port field i equal to j only if req_in bit i*N+j was set when start was accepted.
- R4: No output index is reported for more than one valid input.
- R5: In each round, each free output chooses the first requesting free input at or after its grant pointer, wrapping modulo N. Each input with offers takes the first offering output at or after its accept pointer.
- R6: Only pairs formed in the first round update pointers. The grant pointer of output j becomes (i+1) mod N and the accept pointer of input i becomes (j+1) mod N. Rounds after the first leave all pointers unchanged.
- R7: Pairs formed in a round are kept, and later rounds pair only free inputs with free outputs. With ITER equal to N, no free input is left with a request to a free output.
- R8: A start pulse while a matching is in progress is ignored. Changes on req_in after start has been accepted have no effect on the result.
- R9: An all-zero request set still yields a done pulse, and every match_valid bit is zero.
- R10: match_valid and match_port hold their values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserted asynchronously, released synchronously |
| start | input | 1 | Pulse that begins a matching when the scheduler is idle |
| req_in | input | N*N | Request bits. Bit i*N+j means input i holds a cell for output j |
| done | output | 1 | One-cycle pulse when the matching is final |
| match_valid | output | N | Bit i is set when input i is paired |
| match_port | output | N*clog2(N) | Field i (bits i*IW upward) is the output paired with input i |

## Verification
The assertions assume that rst_n is released away from a clock edge. They also assume that req_in and start are stable around every rising edge. The bench drives all inputs only on falling edges to meet this. The arbiter checks rely on every round seeing a mask of free ports that only shrinks, which the scheduler keeps by never undoing a pair. Stimulus runs a long pseudo-random series of request sets that depend on earlier pointer state, plus fixed corner patterns. These include mid-run start pulses and req_in changes after start, to cover R8.

// File: rtl/islip_pkg.sv
package islip_pkg;
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/islip_rr_arb.sv
module islip_rr_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          vld
);
  // scan N positions beginning at the pointer, first hit wins
  always_comb begin
    int p;
    gnt = '0;
    idx = '0;
    vld = 1'b0;
    for (int k = 0; k < N; k++) begin
      p = int'(ptr) + k;
      if (p >= N) p = p - N;
      if (!vld && req[p]) begin
        vld    = 1'b1;
        gnt[p] = 1'b1;
        idx    = IW'(p);
      end
    end
  end

  // R5: at most one winner, only among requesters, and one whenever any request exists
  always_comb begin
    p_gnt_onehot_r5: assert ($onehot0(gnt));
    p_gnt_subset_r5: assert ((gnt & ~req) == '0);
    p_gnt_live_r5:   assert (vld == (|req));
  end
endmodule

// File: rtl/islip_ptr_bank.sv
module islip_ptr_bank #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    upd,
  input  logic [N*IW-1:0] hit_idx,
  output logic [N*IW-1:0] ptr
);
  logic [IW-1:0] ptr_q [N];
  logic [IW-1:0] ptr_d [N];

  // next pointer is one past the index that was paired, with wrap
  always_comb begin
    for (int k = 0; k < N; k++) begin
      ptr_d[k] = ptr_q[k];
      if (upd[k]) begin
        if (hit_idx[k*IW +: IW] == IW'(N-1)) ptr_d[k] = '0;
        else                                ptr_d[k] = hit_idx[k*IW +: IW] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) ptr_q[k] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (upd[k]) ptr_q[k] <= ptr_d[k];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign ptr[g*IW +: IW] = ptr_q[g];
  end
endmodule

// File: rtl/islip_sched.sv
module islip_sched #(
  parameter int N    = 4,
  parameter int ITER = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [N*N-1:0]                         req_in,
  output logic                                   done,
  output logic [N-1:0]                           match_valid,
  output logic [N*((N > 1) ? $clog2(N) : 1)-1:0] match_port
);
  import islip_pkg::*;

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;

  phase_e        ph_q, ph_d;
  logic [CW-1:0] it_q, it_d;
  logic          done_q, done_d;
  logic          load;
  logic [N-1:0]  req_q [N];
  logic [N-1:0]  in_m_q, in_m_d, out_m_q, out_m_d;
  logic [IW-1:0] port_q [N];
  logic [IW-1:0] port_d [N];

  logic [N*IW-1:0] gptr, aptr;
  logic [N-1:0]    g_req [N];
  logic [N-1:0]    g_gnt [N];
  logic [IW-1:0]   g_idx [N];
  logic [N-1:0]    g_vld;
  logic [N-1:0]    a_req [N];
  logic [N-1:0]    a_gnt [N];
  logic [IW-1:0]   a_idx [N];
  logic [N-1:0]    a_vld;
  logic            first;
  logic [N-1:0]    g_upd, a_upd;
  logic [N*IW-1:0] g_hit, a_hit;

  // request masking: only free inputs and free outputs take part
  always_comb begin
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        g_req[j][i] = req_q[i][j] & ~in_m_q[i] & ~out_m_q[j] & (ph_q == PH_RUN);
        a_req[i][j] = g_gnt[j][i];
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_out_arb
    islip_rr_arb #(.N(N), .IW(IW)) u_grant (
      .req (g_req[j]),
      .ptr (gptr[j*IW +: IW]),
      .gnt (g_gnt[j]),
      .idx (g_idx[j]),
      .vld (g_vld[j])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_in_arb
    islip_rr_arb #(.N(N), .IW(IW)) u_accept (
      .req (a_req[i]),
      .ptr (aptr[i*IW +: IW]),
      .gnt (a_gnt[i]),
      .idx (a_idx[i]),
      .vld (a_vld[i])
    );
  end

  // pointer updates from first-round pairs only
  assign first = (ph_q == PH_RUN) && (it_q == '0);

  always_comb begin
    for (int j = 0; j < N; j++) begin
      g_upd[j]          = first && g_vld[j] && a_vld[g_idx[j]] && (a_idx[g_idx[j]] == IW'(j));
      g_hit[j*IW +: IW] = g_idx[j];
    end
    for (int i = 0; i < N; i++) begin
      a_upd[i]          = first && a_vld[i];
      a_hit[i*IW +: IW] = a_idx[i];
    end
  end

  islip_ptr_bank #(.N(N), .IW(IW)) u_gptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (g_upd),
    .hit_idx (g_hit),
    .ptr     (gptr)
  );

  islip_ptr_bank #(.N(N), .IW(IW)) u_aptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (a_upd),
    .hit_idx (a_hit),
    .ptr     (aptr)
  );

  // round sequencing and match accumulation
  always_comb begin
    ph_d    = ph_q;
    it_d    = it_q;
    done_d  = 1'b0;
    load    = 1'b0;
    in_m_d  = in_m_q;
    out_m_d = out_m_q;
    for (int i = 0; i < N; i++) port_d[i] = port_q[i];
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          load    = 1'b1;
          ph_d    = PH_RUN;
          it_d    = '0;
          in_m_d  = '0;
          out_m_d = '0;
          for (int i = 0; i < N; i++) port_d[i] = '0;
        end
      end
      default: begin
        for (int i = 0; i < N; i++) begin
          if (a_vld[i]) begin
            in_m_d[i]           = 1'b1;
            out_m_d[a_idx[i]]   = 1'b1;
            port_d[i]           = a_idx[i];
          end
        end
        if (it_q == CW'(ITER-1)) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end else begin
          it_d = it_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      it_q    <= '0;
      done_q  <= 1'b0;
      in_m_q  <= '0;
      out_m_q <= '0;
      for (int i = 0; i < N; i++) begin
        port_q[i] <= '0;
        req_q[i]  <= '0;
      end
    end else begin
      ph_q    <= ph_d;
      it_q    <= it_d;
      done_q  <= done_d;
      in_m_q  <= in_m_d;
      out_m_q <= out_m_d;
      for (int i = 0; i < N; i++) begin
        port_q[i] <= port_d[i];
        if (load) req_q[i] <= req_in[i*N +: N];
      end
    end
  end

  assign done        = done_q;
  assign match_valid = in_m_q;
  for (genvar i = 0; i < N; i++) begin : g_port_out
    assign match_port[i*IW +: IW] = port_q[i];
  end

  // ---------------- assertions ----------------
  logic [N-1:0] col_use [N];
  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        col_use[j][i] = in_m_q[i] && (port_q[i] == IW'(j));
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RUN && it_q != CW'(ITER-1)) |=> (ph_q == PH_RUN));

  p_ptr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RUN && it_q != '0) |=> ($stable(gptr) && $stable(aptr)));

  p_keep_pairs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RUN) |=> ((in_m_q & $past(in_m_q)) == $past(in_m_q)));

  for (genvar j = 0; j < N; j++) begin : g_chk_col
    p_out_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $onehot0(col_use[j]));
  end

  for (genvar i = 0; i < N; i++) begin : g_chk_req
    p_req_backed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && in_m_q[i]) |-> req_q[i][port_q[i]]);
  end
endmodule

// File: tb/islip_sched_test.sv
`timescale 1ns/1ps
module islip_sched_test;
  localparam int N    = 4;
  localparam int ITER = 4;
  localparam int IW   = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [N*N-1:0]  req_in;
  logic            done;
  logic [N-1:0]    match_valid;
  logic [N*IW-1:0] match_port;

  int errs   = 0;
  int checks = 0;
  int gp [N];
  int ap [N];
  int exp_acc [N];

  always #2 clk = ~clk;

  islip_sched #(.N(N), .ITER(ITER)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_in      (req_in),
    .done        (done),
    .match_valid (match_valid),
    .match_port  (match_port)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // expected matching from the round-robin rules (R5, R6, R7)
  task automatic model(input logic [N*N-1:0] pat);
    int inm [N];
    int outm [N];
    int grant [N];
    int acc [N];
    int p;
    for (int i = 0; i < N; i++) begin inm[i] = 0; outm[i] = 0; exp_acc[i] = -1; end
    for (int it = 0; it < ITER; it++) begin
      for (int j = 0; j < N; j++) begin
        grant[j] = -1;
        for (int k = 0; k < N; k++) begin
          p = (gp[j] + k) % N;
          if (grant[j] < 0 && pat[p*N + j] && !inm[p] && !outm[j]) grant[j] = p;
        end
      end
      for (int i = 0; i < N; i++) begin
        acc[i] = -1;
        if (!inm[i]) begin
          for (int k = 0; k < N; k++) begin
            p = (ap[i] + k) % N;
            if (acc[i] < 0 && grant[p] == i) acc[i] = p;
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        if (acc[i] >= 0) begin
          inm[i] = 1; outm[acc[i]] = 1; exp_acc[i] = acc[i];
          if (it == 0) begin
            gp[acc[i]] = (i + 1) % N;
            ap[i]      = (acc[i] + 1) % N;
          end
        end
      end
    end
  endtask

  task automatic run_case(input logic [N*N-1:0] pat, input bit poke);
    int used [N];
    logic [N-1:0]    v_hold;
    logic [N*IW-1:0] p_hold;
    model(pat);
    @(negedge clk);
    start  = 1'b1;
    req_in = pat;
    @(negedge clk);
    start  = 1'b0;
    req_in = ~pat;                      // R8: later request changes ignored
    for (int c = 1; c <= ITER; c++) begin
      @(negedge clk);
      start = poke && (c == 1);         // R8: start while running
      if (poke && c == 1) req_in = '1;
      if (c < ITER) chk(done == 1'b0, "R2 done early", int'(done), 0);
    end
    start = 1'b0;
    chk(done == 1'b1, "R2 done timing", int'(done), 1);
    for (int j = 0; j < N; j++) used[j] = 0;
    for (int i = 0; i < N; i++) begin
      chk(match_valid[i] == (exp_acc[i] >= 0), "R5 R7 valid bit", int'(match_valid[i]),
          int'(exp_acc[i] >= 0));
      if (match_valid[i]) begin
        chk(int'(match_port[i*IW +: IW]) == exp_acc[i], "R5 R6 port", int'(match_port[i*IW +: IW]),
            exp_acc[i]);
        chk(pat[i*N + int'(match_port[i*IW +: IW])] == 1'b1, "R3 requested", 0, 1);
        used[match_port[i*IW +: IW]]++;
      end
    end
    for (int j = 0; j < N; j++) chk(used[j] <= 1, "R4 output once", used[j], 1);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (pat[i*N + j] && !match_valid[i] && used[j] == 0)
          chk(1'b0, "R7 maximal", i*N + j, -1);
    v_hold = match_valid;
    p_hold = match_port;
    @(negedge clk);
    chk(done == 1'b0, "R2 done width", int'(done), 0);
    chk(match_valid == v_hold && match_port == p_hold, "R10 hold", int'(match_valid), int'(v_hold));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int k = 0; k < N; k++) begin gp[k] = 0; ap[k] = 0; end
    rst_n  = 1'b0;
    start  = 1'b0;
    req_in = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done reset", int'(done), 0);
    chk(match_valid == '0, "R1 valid reset", int'(match_valid), 0);
    rst_n = 1'b1;
    run_case('1, 1'b0);                 // R1: identity from zero pointers
    chk(match_port == 8'hE4, "R1 identity", int'(match_port), 228);
    run_case('1, 1'b0);                 // R6: desynchronised pointers
    run_case('0, 1'b0);                 // R9: nothing requested
    chk(match_valid == '0, "R9 empty", int'(match_valid), 0);
    run_case(16'h8421, 1'b1);           // R8: poke during run
    run_case(16'h1248, 1'b0);
    run_case(16'h000F, 1'b0);           // one input wants all
    run_case(16'h1111, 1'b0);           // all inputs want one output
    seed = 32'h1234_5678;
    for (int n = 0; n < 2500; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      run_case(seed[23:8], n % 97 == 0);
    end
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule